// File: doc/BRIEF.md
# Power-Mode Clock Source Controller

This controller picks the system clock source from a requested power mode and drives the enable of each oscillator. There are seven operating modes: two run on the primary oscillator, two on the secondary (timer) oscillator, two on the internal oscillator block, and one is sleep. In each source pair, one mode is a run mode and one is an idle mode. Inside the internal block, the clock is either the slow internal source used directly or the fast internal source thinned by a power-of-two postscaler. The postscaler is modelled as a clock-enable pulse train. Oscillators are represented by ready inputs and by a fast-tick input, so no analog start-up is modelled.

Keep-alive demands from the watchdog and from the real-time timer hold their oscillators running in any mode, sleep included. A change of source is glitch-free. The new oscillator is enabled as soon as it is requested. The clock select, the CPU gate and the peripheral gate keep the old setting until the new source reports ready. While the change is pending, both oscillators stay on.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is held and after its release, the controller applies sleep (`clk_sel` = 0, both gates off) until a run or idle request takes effect.
- R2: `mode_req` codes are 0 primary run, 1 primary idle, 2 secondary run, 3 secondary idle, 4 internal run, 5 internal idle, 6 sleep. The primary enable is high only while the requested or applied source is the primary oscillator, so in steady state it is high in modes 0 and 1 only.
- R3: The secondary enable is high when the requested or applied source is the secondary oscillator, or when `rtc_keep` is high, in any mode.
- R4: In modes 4 and 5 with `slow_direct` = 0, the fast internal enable is high. With `slow_direct` = 1 in those modes, the fast enable is low once the switch has completed.
- R5: The slow internal enable is high when the slow source is the requested or applied source, and whenever `wdt_keep` is high, including in sleep.
- R6: In sleep with no keep-alive demand, all four oscillator enables are low.
- R7: The gates follow the applied mode. In run modes `cpu_gate` and `per_gate` are both 1. In idle modes `cpu_gate` is 0 and `per_gate` is 1. In sleep both are 0.
- R8: `clk_sel` encodes the applied source as 0 none, 1 primary, 2 secondary, 3 fast internal after the postscaler, 4 slow internal. It never takes another value.
- R9: A new request is applied at the first rising edge at which the target source's ready input is high. Until then `clk_sel` and the gates hold their previous values, and the old and new oscillator enables are both high.
- R10: While the fast enable is high, `fast_div_ce` pulses once per 2^`post_div` high cycles of `fast_tick`, for `post_div` 0 to 7. While the fast enable is low, `fast_div_ce` stays low.
- R11: `mode_req` code 7 behaves exactly as sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 3 | Requested power mode |
| slow_direct | input | 1 | Internal modes: 1 uses the slow source directly, 0 uses the divided fast source |
| post_div | input | 3 | Postscaler exponent for the fast source |
| wdt_keep | input | 1 | Watchdog keep-alive for the slow internal source |
| rtc_keep | input | 1 | Timer keep-alive for the secondary oscillator |
| pri_rdy | input | 1 | Primary oscillator ready |
| sec_rdy | input | 1 | Secondary oscillator ready |
| fast_rdy | input | 1 | Fast internal oscillator ready |
| slow_rdy | input | 1 | Slow internal oscillator ready |
| fast_tick | input | 1 | One-cycle pulse per fast oscillator period |
| pri_en | output | 1 | Primary oscillator enable |
| sec_en | output | 1 | Secondary oscillator enable |
| fast_en | output | 1 | Fast internal oscillator enable |
| slow_en | output | 1 | Slow internal oscillator enable |
| cpu_gate | output | 1 | CPU clock gate |
| per_gate | output | 1 | Peripheral clock gate |
| clk_sel | output | 3 | Applied clock source code |
| fast_div_ce | output | 1 | Postscaled fast clock enable |

## Verification
The bench builds the block with its default parameters: a 3-bit mode field and a 3-bit postscaler exponent. These defaults make every mode code reachable, including the spare code 7, and every division ratio up to 128. A 256-tick counting window is a whole number of periods for each of the eight ratios, so the expected pulse count is exact at any counter phase. The bench holds one ready input low to keep a switch pending, then checks the source overlap and the frozen select.

// File: rtl/pwr_clk_pkg.sv
`timescale 1ns/1ps
package pwr_clk_pkg;
  typedef enum logic [2:0] {
    M_PRI_RUN  = 3'd0, M_PRI_IDLE = 3'd1,
    M_SEC_RUN  = 3'd2, M_SEC_IDLE = 3'd3,
    M_RC_RUN   = 3'd4, M_RC_IDLE  = 3'd5,
    M_SLEEP    = 3'd6, M_SPARE    = 3'd7
  } pmode_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_PRI = 3'd1, SRC_SEC = 3'd2,
    SRC_FAST = 3'd3, SRC_SLOW = 3'd4
  } src_e;

  typedef struct packed {
    logic pri;
    logic sec;
    logic fast;
    logic slow;
  } osc_vec_t;

  function automatic src_e mode_source(pmode_e m, logic slow_direct);
    case (m)
      M_PRI_RUN, M_PRI_IDLE: return SRC_PRI;
      M_SEC_RUN, M_SEC_IDLE: return SRC_SEC;
      M_RC_RUN, M_RC_IDLE:   return slow_direct ? SRC_SLOW : SRC_FAST;
      default:               return SRC_NONE;
    endcase
  endfunction

  function automatic osc_vec_t source_need(src_e s);
    osc_vec_t v;
    v = '0;
    case (s)
      SRC_PRI:  v.pri  = 1'b1;
      SRC_SEC:  v.sec  = 1'b1;
      SRC_FAST: v.fast = 1'b1;
      SRC_SLOW: v.slow = 1'b1;
      default:  v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pcc_target.sv
`timescale 1ns/1ps
module pcc_target
  import pwr_clk_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_req,
  input  logic              slow_direct,
  output pmode_e            tgt_mode,
  output src_e              tgt_src
);
  pmode_e raw;

  always_comb begin
    raw = pmode_e'(mode_req[2:0]);
    // spare code folds onto sleep
    tgt_mode = (raw == M_SPARE) ? M_SLEEP : raw;
    tgt_src  = mode_source(tgt_mode, slow_direct);
  end
endmodule

// File: rtl/pcc_switch.sv
`timescale 1ns/1ps
module pcc_switch
  import pwr_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pmode_e   tgt_mode,
  input  src_e     tgt_src,
  input  osc_vec_t osc_rdy,
  output pmode_e   cur_mode,
  output src_e     cur_src,
  output logic     cpu_gate,
  output logic     per_gate
);
  logic tgt_ready;
  logic differs;

  always_comb begin
    case (tgt_src)
      SRC_PRI:  tgt_ready = osc_rdy.pri;
      SRC_SEC:  tgt_ready = osc_rdy.sec;
      SRC_FAST: tgt_ready = osc_rdy.fast;
      SRC_SLOW: tgt_ready = osc_rdy.slow;
      default:  tgt_ready = 1'b1;
    endcase
    differs = (tgt_mode != cur_mode) || (tgt_src != cur_src);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= M_SLEEP;
      cur_src  <= SRC_NONE;
    end else if (differs && tgt_ready) begin
      cur_mode <= tgt_mode;
      cur_src  <= tgt_src;
    end
  end

  always_comb begin
    case (cur_mode)
      M_PRI_RUN, M_SEC_RUN, M_RC_RUN:    begin cpu_gate = 1'b1; per_gate = 1'b1; end
      M_PRI_IDLE, M_SEC_IDLE, M_RC_IDLE: begin cpu_gate = 1'b0; per_gate = 1'b1; end
      default:                           begin cpu_gate = 1'b0; per_gate = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pcc_enables.sv
`timescale 1ns/1ps
module pcc_enables
  import pwr_clk_pkg::*;
(
  input  src_e     tgt_src,
  input  src_e     cur_src,
  input  logic     wdt_keep,
  input  logic     rtc_keep,
  output osc_vec_t osc_en
);
  osc_vec_t keep;

  always_comb begin
    keep      = '0;
    keep.sec  = rtc_keep;
    keep.slow = wdt_keep;
    // old and new source overlap while a switch is pending
    osc_en = source_need(tgt_src) | source_need(cur_src) | keep;
  end
endmodule

// File: rtl/pcc_postscaler.sv
`timescale 1ns/1ps
module pcc_postscaler #(
  parameter int PS_W  = 3,
  localparam int CNT_W = (1 << PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            fast_tick,
  input  logic [PS_W-1:0] post_div,
  output logic            ce
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i < int'(post_div)) mask[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (fast_tick)      cnt <= cnt + 1'b1;
  end

  assign ce = run && fast_tick && ((cnt & mask) == mask);
endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              slow_direct,
  input  logic [PS_W-1:0]   post_div,
  input  logic              wdt_keep,
  input  logic              rtc_keep,
  input  logic              pri_rdy,
  input  logic              sec_rdy,
  input  logic              fast_rdy,
  input  logic              slow_rdy,
  input  logic              fast_tick,
  output logic              pri_en,
  output logic              sec_en,
  output logic              fast_en,
  output logic              slow_en,
  output logic              cpu_gate,
  output logic              per_gate,
  output logic [2:0]        clk_sel,
  output logic              fast_div_ce
);
  pmode_e   tgt_mode, cur_mode;
  src_e     tgt_src, cur_src;
  osc_vec_t rdy_v, en_v;

  assign rdy_v = '{pri: pri_rdy, sec: sec_rdy, fast: fast_rdy, slow: slow_rdy};

  pcc_target #(.MODE_W(MODE_W)) u_target (
    .mode_req(mode_req), .slow_direct(slow_direct),
    .tgt_mode(tgt_mode), .tgt_src(tgt_src)
  );

  pcc_switch u_switch (
    .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .tgt_src(tgt_src),
    .osc_rdy(rdy_v), .cur_mode(cur_mode), .cur_src(cur_src),
    .cpu_gate(cpu_gate), .per_gate(per_gate)
  );

  pcc_enables u_enables (
    .tgt_src(tgt_src), .cur_src(cur_src),
    .wdt_keep(wdt_keep), .rtc_keep(rtc_keep), .osc_en(en_v)
  );

  pcc_postscaler #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst_n(rst_n), .run(en_v.fast), .fast_tick(fast_tick),
    .post_div(post_div), .ce(fast_div_ce)
  );

  assign pri_en  = en_v.pri;
  assign sec_en  = en_v.sec;
  assign fast_en = en_v.fast;
  assign slow_en = en_v.slow;
  assign clk_sel = cur_src;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_chk #(
  parameter int MODE_W = 3,
  parameter int PS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_req,
  input logic              slow_direct,
  input logic [PS_W-1:0]   post_div,
  input logic              wdt_keep,
  input logic              rtc_keep,
  input logic              pri_rdy,
  input logic              sec_rdy,
  input logic              fast_rdy,
  input logic              slow_rdy,
  input logic              fast_tick,
  input logic              pri_en,
  input logic              sec_en,
  input logic              fast_en,
  input logic              slow_en,
  input logic              cpu_gate,
  input logic              per_gate,
  input logic [2:0]        clk_sel,
  input logic              fast_div_ce
);
  logic [7:0] rdy_q;
  logic       rc_mode;

  assign rc_mode = (mode_req == 3'd4) || (mode_req == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 8'h01;
    else        rdy_q <= {3'b000, slow_rdy, fast_rdy, sec_rdy, pri_rdy, 1'b1};
  end

  AST_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 3'd1 && mode_req > 3'd1) |-> !pri_en); // R2
  AST_RTC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_keep |-> sec_en); // R3
  AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd4 && rc_mode && slow_direct) |-> !fast_en); // R4
  AST_WDT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_keep |-> slow_en); // R5
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> (!cpu_gate && !per_gate)); // R7
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel <= 3'd4); // R8
  AST_SEL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> rdy_q[clk_sel]); // R9
  AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |-> !fast_div_ce); // R10
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.MODE_W(MODE_W), .PS_W(PS_W)) u_chk (.*);

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_req = 3'd6;
  logic slow_direct = 1'b0;
  logic [2:0] post_div = 3'd0;
  logic wdt_keep = 1'b0, rtc_keep = 1'b0;
  logic pri_rdy = 1'b1, sec_rdy = 1'b1, fast_rdy = 1'b1, slow_rdy = 1'b1;
  logic fast_tick = 1'b0;
  logic pri_en, sec_en, fast_en, slow_en, cpu_gate, per_gate, fast_div_ce;
  logic [2:0] clk_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_clk_ctrl uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sel(int m, bit sd);
    case (m)
      0, 1: return 1;
      2, 3: return 2;
      4, 5: return sd ? 4 : 3;
      default: return 0;
    endcase
  endfunction

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "sel in reset", clk_sel, 0);
    chk("R1", "cpu gate in reset", cpu_gate, 0);
    mode_req = 3'd6;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sel after reset", clk_sel, 0);
    chk("R1", "per gate after reset", per_gate, 0);
  endtask

  task automatic truth_table_test();
    for (int m = 0; m < 8; m++)
      for (int sd = 0; sd < 2; sd++)
        for (int k = 0; k < 4; k++) begin
          int s;
          @(negedge clk);
          mode_req = 3'(m); slow_direct = sd[0];
          wdt_keep = k[0]; rtc_keep = k[1];
          @(negedge clk);
          s = ref_sel(m, sd[0]);
          chk((m == 7) ? "R11" : "R8", "clk_sel", clk_sel, s);
          chk("R2", "pri_en", pri_en, int'(s == 1));
          chk("R3", "sec_en", sec_en, int'(s == 2 || k[1]));
          chk("R4", "fast_en", fast_en, int'(s == 3));
          chk("R5", "slow_en", slow_en, int'(s == 4 || k[0]));
          chk("R7", "cpu_gate", cpu_gate, int'(m == 0 || m == 2 || m == 4));
          chk("R7", "per_gate", per_gate, int'(m < 6));
          if (s == 0 && k == 0)
            chk("R6", "all enables in sleep",
                {pri_en, sec_en, fast_en, slow_en}, 0);
        end
    wdt_keep = 1'b0; rtc_keep = 1'b0;
  endtask

  task automatic switch_test();
    @(negedge clk);
    mode_req = 3'd0; slow_direct = 1'b0;
    @(negedge clk);
    chk("R9", "start on primary", clk_sel, 1);
    sec_rdy = 1'b0;
    mode_req = 3'd3;
    repeat (3) @(negedge clk);
    chk("R9", "sel held while pending", clk_sel, 1);
    chk("R9", "cpu gate held while pending", cpu_gate, 1);
    chk("R9", "old source kept", pri_en, 1);
    chk("R9", "new source enabled", sec_en, 1);
    sec_rdy = 1'b1;
    @(negedge clk);
    chk("R9", "sel after ready", clk_sel, 2);
    chk("R9", "idle cpu gate after ready", cpu_gate, 0);
    chk("R9", "old source released", pri_en, 0);
  endtask

  task automatic postscaler_test();
    int pulses;
    @(negedge clk);
    mode_req = 3'd4; slow_direct = 1'b0; fast_tick = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      post_div = 3'(p);
      pulses = 0;
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        if (fast_div_ce) pulses++;
      end
      chk("R10", $sformatf("pulses div exp %0d", p), pulses, 256 >> p);
    end
    slow_direct = 1'b1; post_div = 3'd0;
    @(negedge clk);
    pulses = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (fast_div_ce) pulses++;
    end
    chk("R10", "no pulses with fast off", pulses, 0);
    chk("R4", "fast off in slow direct", fast_en, 0);
    fast_tick = 1'b0;
  endtask

  initial begin
    reset_test();
    truth_table_test();
    switch_test();
    postscaler_test();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule